// File: doc/BRIEF.md
# Rational Sample-Rate Conversion Chain

This block resamples a stream of 8-bit signed biosignal samples by a rational ratio L/M. It chains three stages: a zero-stuffing upsampler that follows every sample with L-1 zeros, a five-tap symmetric smoothing FIR, and a decimator that passes one sample and drops the following M-1. A static order input picks whether the stream is stuffed first and thinned last, or thinned first and stuffed last. L and M are set at run time from the set {1, 2, 3} and need not be equal, so the net output rate is L/M times the input rate.

Samples enter on a valid-qualified port with a ready signal and leave on a valid-qualified port, all on one clock. The upsampler emits one sample per cycle. The block therefore holds its input ready low for L-1 cycles after any sample that will reach the upsampler. The output carries the full-precision filter result, so no rounding or saturation takes place anywhere in the chain.

Top module: `rsrc_chain`

## Requirements
- R1: For every sample that reaches the upsampler, the upsampler emits that sample and then L-1 zero samples on the following cycles, one per cycle.
- R2: The decimator forwards the first sample it sees, drops the next M-1, and repeats this pattern for the rest of the stream.
- R3: The filter computes y = 1*x[n] + 3*x[n-1] + 7*x[n-2] + 3*x[n-3] + 1*x[n-4] on its own input stream. The result is a 12-bit two's-complement value that never overflows, so it lies within -1920..1905.
- R4: After reset every filter history register is zero, so the first outputs match a stream that was preceded by zeros.
- R5: With order = 0 the chain is upsample, filter, downsample. With order = 1 it is downsample, filter, upsample.
- R6: After accepting a sample that will reach the upsampler, in_ready is low for exactly L-1 cycles. In order 1, a sample that the decimator drops leaves in_ready high.
- R7: The decimator phase is zero after reset, so the first input sample after reset always passes the decimator.
- R8: A factor code of 0 on up_factor or down_factor behaves as a factor of 1. Codes 1, 2 and 3 mean factors 1, 2 and 3.
- R9: While reset is held and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R10: An input sample that produces an output appears on out_valid/out_sample at the second rising edge after the edge that accepted it, in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all stages |
| rst | input | 1 | Synchronous active-high reset. order and the factors may change only while it is high |
| order | input | 1 | Stage order: 0 = stuff, filter, thin; 1 = thin, filter, stuff |
| up_factor | input | 2 | Upsampling factor L (0 is read as 1) |
| down_factor | input | 2 | Downsampling factor M (0 is read as 1) |
| in_valid | input | 1 | Input sample present |
| in_sample | input | 8 | Input sample, two's complement |
| in_ready | output | 1 | Block accepts a sample on this cycle |
| out_valid | output | 1 | Output sample present |
| out_sample | output | 12 | Output sample, two's complement, full filter precision |

## Verification
The bench aims at the pacing of in_ready. If the pause after an accepted sample is off by one cycle, samples reach the upsampler while it is still stuffing zeros and the output stream loses samples. If in order 1 the pause is applied to dropped samples, the input rate halves with no change to the values, and only the count and the ready timing expose it. Unequal ratios in both orders are compared sample by sample with a model built from the requirements, since a swapped stage order or a decimator phase that starts at one gives a plausible but shifted stream. Full-scale alternating inputs probe the accumulator width, where a narrow sum would wrap the large peaks. A factor code of 0 and the stream right after reset probe the degenerate ratio and the zeroed history.

// File: rtl/rsrc_pkg.sv
`timescale 1ns/1ps
package rsrc_pkg;

    localparam int SAMPLE_W = 8;
    localparam int TAPS     = 5;
    localparam int FACTOR_W = 2;

    function automatic int tap_coef(input int idx);
        case (idx)
            0: return 1;
            1: return 3;
            2: return 7;
            3: return 3;
            4: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int coef_gain();
        int s;
        s = 0;
        for (int i = 0; i < TAPS; i++) s += tap_coef(i);
        return s;
    endfunction

    localparam int GAIN  = coef_gain();
    localparam int ACC_W = SAMPLE_W + $clog2(GAIN + 1);
    localparam int ACC_MAX = GAIN * ((1 << (SAMPLE_W - 1)) - 1);
    localparam int ACC_MIN = -GAIN * (1 << (SAMPLE_W - 1));

    typedef logic signed [SAMPLE_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic [FACTOR_W-1:0]        fac_t;

    typedef struct packed {
        logic vld;
        acc_t dat;
    } beat_t;

    typedef enum logic {
        ORDER_UP_FIRST   = 1'b0,
        ORDER_DOWN_FIRST = 1'b1
    } order_e;

    function automatic fac_t eff_factor(input fac_t f);
        return (f == '0) ? fac_t'(1) : f;
    endfunction

endpackage

// File: rtl/rsrc_upsampler.sv
`timescale 1ns/1ps
module rsrc_upsampler
    import rsrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fac_t  factor,
    input  beat_t ib,
    output beat_t ob
);
    fac_t left;
    fac_t lf;

    assign lf = eff_factor(factor);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            ob   <= '0;
        end else if (ib.vld) begin
            ob.vld <= 1'b1;
            ob.dat <= ib.dat;
            left   <= lf - fac_t'(1);
        end else if (left != '0) begin
            ob.vld <= 1'b1;
            ob.dat <= '0;
            left   <= left - fac_t'(1);
        end else begin
            ob.vld <= 1'b0;
            ob.dat <= '0;
        end
    end

    // R6: the front pacing must keep new samples away while zeros are pending
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        ib.vld |-> (left == '0));

    // R1: a pending zero is emitted on the next cycle
    a_r1_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (!ib.vld && left != '0) |=> (ob.vld && ob.dat == '0));

endmodule

// File: rtl/rsrc_decimator.sv
`timescale 1ns/1ps
module rsrc_decimator
    import rsrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fac_t  factor,
    input  beat_t ib,
    output beat_t ob,
    output logic  keep_now
);
    fac_t phase;
    fac_t mf;

    assign mf       = eff_factor(factor);
    assign keep_now = (phase == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            ob    <= '0;
        end else if (ib.vld) begin
            ob.vld <= keep_now;
            ob.dat <= keep_now ? ib.dat : acc_t'(0);
            phase  <= (phase == mf - fac_t'(1)) ? fac_t'(0) : phase + fac_t'(1);
        end else begin
            ob.vld <= 1'b0;
        end
    end

    // R2: a sample arriving off-phase never reaches the output
    a_r2_drop: assert property (@(posedge clk) disable iff (rst)
        (ib.vld && !keep_now) |=> !ob.vld);

    // R7: the phase never leaves the range set by the factor
    a_r7_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase < mf);

endmodule

// File: rtl/rsrc_fir.sv
`timescale 1ns/1ps
module rsrc_fir
    import rsrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  smp_t  in_x,
    output beat_t ob
);
    smp_t hist [TAPS-1];
    acc_t prod [TAPS];
    acc_t total;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        if (g == 0) begin : g_new
            assign prod[g] = acc_t'(in_x) * acc_t'(tap_coef(g));
        end else begin : g_old
            assign prod[g] = acc_t'(hist[g-1]) * acc_t'(tap_coef(g));
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < TAPS; i++) total += prod[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
            ob <= '0;
        end else if (in_vld) begin
            hist[0] <= in_x;
            for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
            ob.vld <= 1'b1;
            ob.dat <= total;
        end else begin
            ob.vld <= 1'b0;
        end
    end

    // R3: result stays inside the exact range of an 8-bit input times the gain
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ob.vld |-> ($signed(ob.dat) <= ACC_MAX && $signed(ob.dat) >= ACC_MIN));

endmodule

// File: rtl/rsrc_pacer.sv
`timescale 1ns/1ps
module rsrc_pacer
    import rsrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  fac_t factor,
    input  logic fire,
    output logic ready
);
    fac_t hold;

    assign ready = (hold == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (fire) begin
            hold <= eff_factor(factor) - fac_t'(1);
        end else if (hold != '0) begin
            hold <= hold - fac_t'(1);
        end
    end

    // R6: a sample headed for the upsampler closes the input when L > 1
    a_r6_pause: assert property (@(posedge clk) disable iff (rst)
        (fire && eff_factor(factor) > fac_t'(1)) |=> !ready);

endmodule

// File: rtl/rsrc_chain.sv
`timescale 1ns/1ps
module rsrc_chain
    import rsrc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                order,
    input  logic [FACTOR_W-1:0] up_factor,
    input  logic [FACTOR_W-1:0] down_factor,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                in_ready,
    output logic                out_valid,
    output logic [ACC_W-1:0]    out_sample
);
    order_e ord;
    logic   accept;
    logic   keep_now;
    logic   fire;
    beat_t  src_b, up_in, up_out, dn_in, dn_out, fir_out, fir_in_b, sink_b;

    assign ord       = order_e'(order);
    assign accept    = in_valid && in_ready;
    assign src_b.vld = accept;
    assign src_b.dat = acc_t'($signed(in_sample));

    // a sample reaches the upsampler always when it leads, else only if kept
    assign fire = accept && ((ord == ORDER_UP_FIRST) || keep_now);

    always_comb begin
        if (ord == ORDER_UP_FIRST) begin
            up_in    = src_b;
            fir_in_b = up_out;
            dn_in    = fir_out;
            sink_b   = dn_out;
        end else begin
            dn_in    = src_b;
            fir_in_b = dn_out;
            up_in    = fir_out;
            sink_b   = up_out;
        end
    end

    rsrc_pacer u_pacer (
        .clk    (clk),
        .rst    (rst),
        .factor (up_factor),
        .fire   (fire),
        .ready  (in_ready)
    );

    rsrc_upsampler u_up (
        .clk    (clk),
        .rst    (rst),
        .factor (up_factor),
        .ib     (up_in),
        .ob     (up_out)
    );

    rsrc_fir u_fir (
        .clk    (clk),
        .rst    (rst),
        .in_vld (fir_in_b.vld),
        .in_x   (smp_t'(fir_in_b.dat[SAMPLE_W-1:0])),
        .ob     (fir_out)
    );

    rsrc_decimator u_dn (
        .clk      (clk),
        .rst      (rst),
        .factor   (down_factor),
        .ib       (dn_in),
        .ob       (dn_out),
        .keep_now (keep_now)
    );

    assign out_valid  = sink_b.vld;
    assign out_sample = sink_b.dat;

    // R5: configuration is static outside reset
    a_r5_static_cfg: assert property (@(posedge clk) disable iff (rst)
        $stable(order) && $stable(up_factor) && $stable(down_factor));

endmodule

// File: tb/sim_rsrc_chain.sv
`timescale 1ns/1ps
module sim_rsrc_chain;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        order = 1'b0;
    logic [1:0]  up_factor = 2'd1;
    logic [1:0]  down_factor = 2'd1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        in_ready;
    logic        out_valid;
    logic [11:0] out_sample;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int in_q[$];
    int out_q[$];
    int exp_q[$];
    int hist[5];

    always #10 clk = ~clk;

    rsrc_chain u0 (
        .clk(clk), .rst(rst), .order(order), .up_factor(up_factor),
        .down_factor(down_factor), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) out_q.push_back(int'($signed(out_sample)));
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int fir_step(input int x);
        for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        return hist[0] + 3*hist[1] + 7*hist[2] + 3*hist[3] + hist[4];
    endfunction

    task automatic build_expected(input bit ord, input int lf, input int mf);
        int ph;
        int y;
        ph = 0;
        exp_q.delete();
        for (int i = 0; i < 5; i++) hist[i] = 0;  // R4 zero history
        foreach (in_q[k]) begin
            if (!ord) begin
                for (int j = 0; j < lf; j++) begin
                    y = fir_step(j == 0 ? in_q[k] : 0);
                    if (ph == 0) exp_q.push_back(y);
                    ph = (ph + 1) % mf;
                end
            end else begin
                if (ph == 0) begin
                    y = fir_step(in_q[k]);
                    for (int j = 0; j < lf; j++) exp_q.push_back(j == 0 ? y : 0);
                end
                ph = (ph + 1) % mf;
            end
        end
    endtask

    task automatic do_reset(input bit ord, input int lf, input int mf);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        order = ord;
        up_factor = 2'(lf);
        down_factor = 2'(mf);
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9 in reset", {out_valid, in_ready}, 1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9 after reset", {out_valid, in_ready}, 1);
        in_q.delete();
        out_q.delete();
        @(negedge clk);
    endtask

    task automatic send(input int v);
        logic r;
        in_valid = 1'b1;
        in_sample = 8'(v);
        do begin
            #1;
            r = in_ready;
            @(negedge clk);
        end while (!r);
        in_q.push_back(v);
        in_valid = 1'b0;
    endtask

    task automatic run_cfg(input bit ord, input int lf, input int mf, input int n,
                           input int kind, input string req);
        int v;
        do_reset(ord, lf, mf);
        for (int i = 0; i < n; i++) begin
            if (kind == 1) v = (i % 2 == 0) ? 127 : -128;
            else v = int'($urandom_range(255)) - 128;
            send(v);
            if (kind == 0 && $urandom_range(3) == 0) repeat ($urandom_range(3)) @(negedge clk);
        end
        repeat (12) @(negedge clk);
        build_expected(ord, (lf == 0) ? 1 : lf, (mf == 0) ? 1 : mf);
        check(out_q.size() == exp_q.size(), {req, " count"}, out_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < out_q.size(); i++)
            check(out_q[i] == exp_q[i], {req, " value"}, out_q[i], exp_q[i]);
    endtask

    // R6, R10: ready pause and latency of the first kept sample, with L = 3
    task automatic pace(input bit ord, input int mf);
        do_reset(ord, 3, mf);
        send(50);
        #1;
        check(in_ready == 1'b0, "R6 pause cycle 1", in_ready, 0);
        check(out_valid == 1'b0, "R10 not yet 1", out_valid, 0);
        @(negedge clk); #1;
        check(in_ready == 1'b0, "R6 pause cycle 2", in_ready, 0);
        check(out_valid == 1'b0, "R10 not yet 2", out_valid, 0);
        @(negedge clk); #1;
        check(in_ready == 1'b1, "R6 reopen", in_ready, 1);
        check(out_valid == 1'b1 && $signed(out_sample) == 50, "R10 R7 first out",
              int'($signed(out_sample)), 50);
        @(negedge clk);
        send(-20);
        #1;
        if (ord) check(in_ready == 1'b1, "R6 dropped sample no pause", in_ready, 1);
        else     check(in_ready == 1'b0, "R6 up-first pause", in_ready, 0);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        pace(1'b0, 1);
        pace(1'b1, 2);
        // directed: R1 stuffing seen through the filter with M=1
        do_reset(1'b0, 2, 1);
        send(56); send(65); send(89);
        repeat (10) @(negedge clk);
        build_expected(1'b0, 2, 1);
        check(out_q.size() == 6, "R1 stuffed count", out_q.size(), 6);
        for (int i = 0; i < exp_q.size() && i < out_q.size(); i++)
            check(out_q[i] == exp_q[i], "R1 R4 stuffed value", out_q[i], exp_q[i]);
        // R2 decimation with L=1
        run_cfg(1'b0, 1, 2, 30, 0, "R2 thin by 2");
        run_cfg(1'b1, 1, 3, 30, 0, "R2 R7 thin by 3 down-first");
        // R5 both orders, equal and unequal ratios
        run_cfg(1'b0, 2, 2, 40, 0, "R5 up-first 2/2");
        run_cfg(1'b0, 3, 3, 40, 0, "R5 up-first 3/3");
        run_cfg(1'b0, 3, 2, 40, 0, "R5 R6 up-first 3/2");
        run_cfg(1'b1, 2, 2, 40, 0, "R5 down-first 2/2");
        run_cfg(1'b1, 3, 2, 40, 0, "R5 R6 down-first 3/2");
        run_cfg(1'b1, 2, 3, 40, 0, "R5 down-first 2/3");
        // R3 full-scale extremes
        run_cfg(1'b0, 1, 1, 20, 1, "R3 extremes up-first");
        run_cfg(1'b1, 3, 1, 20, 1, "R3 extremes down-first");
        // R8 factor code 0
        run_cfg(1'b0, 0, 0, 20, 0, "R8 zero codes");
        run_cfg(1'b1, 0, 2, 20, 0, "R8 zero L code");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule